// File: doc/BRIEF.md
# Vector Tail-Policy Byte Write-Enable Generator

This block decides, for every byte of one destination vector register, what a vector writeback does with it: store the computed result, store all ones, or leave the old contents alone. It is meant to sit between the element datapath and the register file write port. It has no datapath of its own and makes only the per-byte decision.

The inputs are the operation's start index and length, the source and destination element sizes, and a 5-bit per-operation descriptor. The descriptor carries the unmasked flag, the signed group multiplier code and the tail policy bit. The block also takes the v0 mask bits, the index of the register being written within its group, and a global enable that allows tail bytes to be filled with ones.

The tail is sized from the effective group multiplier of the destination. This multiplier is held at one register when the setting is fractional. As a result, a fractional operation with the fill policy active also fills the bytes of the register that lie past the last valid element. All outputs are registered one cycle after the request. A one-cycle pulse is raised when the last register of the group has been written, or when the operation has no work to do, and this pulse clears the start index.

Top module: `vtail_wen_gen`

## Requirements
- R1: Outputs appear exactly one clock after `in_valid`. While `out_valid` is 0, `result_we`, `ones_we` and `vstart_clr` are all 0.
- R2: With `op_desc[0]`=1 (unmasked), every byte whose element index e satisfies vstart <= e < vl gets `result_we`=1. No byte has both `result_we` and `ones_we` set.
- R3: With `op_desc[0]`=0, a body element e is written only when `v0_mask[e]`=1. Bit i of `v0_mask` belongs to element i. Body bytes whose mask bit is 0 are left untouched.
- R4: Bytes of elements with index below `vstart` (prestart) are never written.
- R5: A tail byte gets `ones_we`=1 only when `op_desc[4]` (tail policy) and `fill_ones_en` are both 1. Otherwise every tail byte is left untouched.
- R6: Byte a of the group has absolute index reg_idx*VLENB+lane and element index a >> esz_log2. When filling is active, bytes with vl*esz <= a < (VLENB << emul) get ones. Here emul = esz_log2 - sew_log2 + lmul, taken as 0 when the sum is negative.
- R7: For a fractional multiplier, emul is 0 and the fill covers the whole single register, including bytes past the last valid element.
- R8: When vl*esz equals the group byte count, no byte gets `ones_we`.
- R9: When vstart >= vl, no byte is written and `vstart_clr` is still pulsed.
- R10: `vstart_clr` pulses with `out_valid` when `reg_idx` equals (1 << emul) - 1 or when R9 applies, and at no other time.
- R11: Descriptor layout: bit 0 = unmasked, bits 3:1 = multiplier code in two's complement (sign-extended before use), bit 4 = tail policy.
- R12: Element sizes are coded as log2 of bytes (0..3 for 1, 2, 4, 8 bytes). The destination size `esz_log2` may be one larger than `sew_log2` for widening ops, and the tail extent uses the destination size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request for one register writeback decision |
| op_desc | input | 5 | Descriptor: [0] unmasked, [3:1] multiplier code, [4] tail policy |
| sew_log2 | input | 2 | log2 of the source element size in bytes |
| esz_log2 | input | 2 | log2 of the destination element size in bytes |
| vstart | input | VL_W (8) | First body element index |
| vl | input | VL_W (8) | Active element count |
| reg_idx | input | REG_W (3) | Register position within the destination group |
| v0_mask | input | MASK_W (128) | Mask bits, one per element |
| fill_ones_en | input | 1 | Global enable for all-ones tail fill |
| out_valid | output | 1 | Registered decision valid |
| result_we | output | VLENB (16) | Per-byte write of the computed result |
| ones_we | output | VLENB (16) | Per-byte write of all ones |
| vstart_clr | output | 1 | Pulse that clears the start index |

## Verification
The assertions assume legal settings. The effective multiplier never exceeds the group limit, `reg_idx` stays inside the destination group, and `vl` does not exceed the maximum element count for the source setting. The random stimulus draws the multiplier and the sizes first. It lowers the multiplier when a widening operation would push the group past eight registers. It then picks `vl` no larger than that maximum, picks `reg_idx` below the group size, and lets `vstart` run one past the maximum so that the no-work case occurs regularly.

// File: rtl/vtail_pkg.sv
package vtail_pkg;

  typedef enum logic [1:0] {
    BW_KEEP   = 2'd0,
    BW_RESULT = 2'd1,
    BW_ONES   = 2'd2
  } byte_act_e;

  // Per-operation descriptor; bit positions are decoded by the issue stage.
  typedef struct packed {
    logic       tail_agn;  // bit 4
    logic [2:0] lmul_code; // bits 3:1
    logic       unmasked;  // bit 0
  } op_desc_t;

  function automatic int lmul_to_int(input logic [2:0] code);
    return int'($signed(code));
  endfunction

  // Effective destination multiplier (log2), clamped to [0, max_emul].
  function automatic int eff_emul(input logic [2:0] lmul_code,
                                  input logic [1:0] sew_log2,
                                  input logic [1:0] esz_log2,
                                  input int         max_emul);
    int raw;
    raw = int'(esz_log2) - int'(sew_log2) + lmul_to_int(lmul_code);
    if (raw < 0)        return 0;
    if (raw > max_emul) return max_emul;
    return raw;
  endfunction

endpackage

// File: rtl/vtail_group_calc.sv
module vtail_group_calc
  import vtail_pkg::*;
#(
  parameter int VLENB    = 16,
  parameter int MAX_REGS = 8,
  localparam int REG_W    = $clog2(MAX_REGS),
  localparam int ABS_W    = $clog2(VLENB * MAX_REGS),
  localparam int MAX_EMUL = $clog2(MAX_REGS),
  localparam int EM_W     = $clog2(MAX_EMUL + 1)
) (
  input  logic [2:0]       lmul_code,
  input  logic [1:0]       sew_log2,
  input  logic [1:0]       esz_log2,
  output logic [ABS_W:0]   grp_bytes,
  output logic [REG_W-1:0] last_reg
);

  logic [EM_W-1:0] emul;

  always_comb begin
    emul      = EM_W'(eff_emul(lmul_code, sew_log2, esz_log2, MAX_EMUL));
    grp_bytes = (ABS_W + 1)'(VLENB) << emul;
    last_reg  = REG_W'((32'd1 << emul) - 32'd1);
  end

endmodule

// File: rtl/vtail_byte_lane.sv
module vtail_byte_lane
  import vtail_pkg::*;
#(
  parameter int VLENB    = 16,
  parameter int MAX_REGS = 8,
  parameter int LANE     = 0,
  localparam int LANE_W = $clog2(VLENB),
  localparam int REG_W  = $clog2(MAX_REGS),
  localparam int ABS_W  = REG_W + LANE_W,
  localparam int MASK_W = VLENB * MAX_REGS,
  localparam int VL_W   = $clog2(MASK_W + 1)
) (
  input  logic [REG_W-1:0]  reg_idx,
  input  logic [1:0]        esz_log2,
  input  logic [VL_W-1:0]   vstart,
  input  logic [VL_W-1:0]   vl,
  input  logic [MASK_W-1:0] v0_mask,
  input  logic              unmasked,
  input  logic              run_en,
  input  logic              fill_en,
  input  logic [ABS_W:0]    grp_bytes,
  output byte_act_e         act
);

  logic [ABS_W-1:0] abs_idx;
  logic [ABS_W-1:0] elem_idx;
  logic [VL_W-1:0]  elem_ext;
  logic             is_prestart;
  logic             is_body;
  logic             is_tail;
  logic             mask_on;

  always_comb begin
    abs_idx     = {reg_idx, LANE_W'(LANE)};
    elem_idx    = abs_idx >> esz_log2;
    elem_ext    = VL_W'(elem_idx);
    is_prestart = elem_ext < vstart;
    is_body     = !is_prestart && (elem_ext < vl);
    is_tail     = (elem_ext >= vl) && ({1'b0, abs_idx} < grp_bytes);
    mask_on     = unmasked || v0_mask[elem_idx];
    act         = BW_KEEP;
    if (run_en) begin
      if (is_body && mask_on)      act = BW_RESULT;
      else if (is_tail && fill_en) act = BW_ONES;
    end
  end

endmodule

// File: rtl/vtail_wen_gen.sv
module vtail_wen_gen
  import vtail_pkg::*;
#(
  parameter int VLENB    = 16,
  parameter int MAX_REGS = 8,
  localparam int REG_W  = $clog2(MAX_REGS),
  localparam int ABS_W  = $clog2(VLENB * MAX_REGS),
  localparam int MASK_W = VLENB * MAX_REGS,
  localparam int VL_W   = $clog2(MASK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4:0]        op_desc,
  input  logic [1:0]        sew_log2,
  input  logic [1:0]        esz_log2,
  input  logic [VL_W-1:0]   vstart,
  input  logic [VL_W-1:0]   vl,
  input  logic [REG_W-1:0]  reg_idx,
  input  logic [MASK_W-1:0] v0_mask,
  input  logic              fill_ones_en,
  output logic              out_valid,
  output logic [VLENB-1:0]  result_we,
  output logic [VLENB-1:0]  ones_we,
  output logic              vstart_clr
);

  op_desc_t         desc;
  logic             early_exit;
  logic             run_en;
  logic             fill_en;
  logic [ABS_W:0]   grp_bytes;
  logic [REG_W-1:0] last_reg;
  logic             clr_next;
  logic [VLENB-1:0] res_next;
  logic [VLENB-1:0] one_next;

  assign desc       = op_desc_t'(op_desc);
  assign early_exit = vstart >= vl;
  assign run_en     = in_valid && !early_exit;
  assign fill_en    = desc.tail_agn && fill_ones_en;
  assign clr_next   = in_valid && (early_exit || (reg_idx == last_reg));

  vtail_group_calc #(.VLENB(VLENB), .MAX_REGS(MAX_REGS)) u_group (
    .lmul_code (desc.lmul_code),
    .sew_log2  (sew_log2),
    .esz_log2  (esz_log2),
    .grp_bytes (grp_bytes),
    .last_reg  (last_reg)
  );

  for (genvar g = 0; g < VLENB; g++) begin : g_lane
    byte_act_e act;
    vtail_byte_lane #(.VLENB(VLENB), .MAX_REGS(MAX_REGS), .LANE(g)) u_lane (
      .reg_idx   (reg_idx),
      .esz_log2  (esz_log2),
      .vstart    (vstart),
      .vl        (vl),
      .v0_mask   (v0_mask),
      .unmasked  (desc.unmasked),
      .run_en    (run_en),
      .fill_en   (fill_en),
      .grp_bytes (grp_bytes),
      .act       (act)
    );
    assign res_next[g] = (act == BW_RESULT);
    assign one_next[g] = (act == BW_ONES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result_we  <= '0;
      ones_we    <= '0;
      vstart_clr <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      result_we  <= res_next;
      ones_we    <= one_next;
      vstart_clr <= clr_next;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (result_we == '0 && ones_we == '0 && !vstart_clr)); // R1
  AST_BYTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (result_we & ones_we) == '0); // R2
  AST_FILL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(op_desc[4] && fill_ones_en)) |=> ones_we == '0); // R5
  AST_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vstart >= vl) |=>
      (result_we == '0 && ones_we == '0 && vstart_clr)); // R9
  AST_CLR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    vstart_clr |-> out_valid); // R10

endmodule

// File: tb/vtail_wen_gen_tb.sv
module vtail_wen_gen_tb;

  localparam int VLENB    = 16;
  localparam int MAX_REGS = 8;
  localparam int REG_W    = $clog2(MAX_REGS);
  localparam int MASK_W   = VLENB * MAX_REGS;
  localparam int VL_W     = $clog2(MASK_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [4:0]        op_desc = '0;
  logic [1:0]        sew_log2 = '0;
  logic [1:0]        esz_log2 = '0;
  logic [VL_W-1:0]   vstart = '0;
  logic [VL_W-1:0]   vl = '0;
  logic [REG_W-1:0]  reg_idx = '0;
  logic [MASK_W-1:0] v0_mask = '0;
  logic              fill_ones_en = 1'b0;
  logic              out_valid;
  logic [VLENB-1:0]  result_we;
  logic [VLENB-1:0]  ones_we;
  logic              vstart_clr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  vtail_wen_gen #(.VLENB(VLENB), .MAX_REGS(MAX_REGS)) u_dut (.*);

  // Reference: integer arithmetic over byte ranges.
  task automatic expect_for(input int lm, input int sew, input int esz,
                            input int vs, input int vln, input int rg,
                            input bit unm, input bit ta, input bit cfg,
                            output logic [VLENB-1:0] er,
                            output logic [VLENB-1:0] eo,
                            output bit ec);
    int em, total, lo;
    em = esz - sew + lm;
    if (em < 0) em = 0;
    total = VLENB << em;
    lo = vln << esz;
    er = '0;
    eo = '0;
    for (int b = 0; b < VLENB; b++) begin
      int a, e;
      a = rg * VLENB + b;
      e = a >> esz;
      if (vs < vln && e >= vs) begin
        if (a < lo) er[b] = unm || v0_mask[e];
        else if (ta && cfg && a < total) eo[b] = 1'b1;
      end
    end
    ec = (vs >= vln) || (rg == (1 << em) - 1);
  endtask

  task automatic run_op(input string req, input int lm, input int sew,
                        input int esz, input int vs, input int vln,
                        input int rg, input bit unm, input bit ta, input bit cfg);
    logic [VLENB-1:0] er, eo;
    bit ec;
    in_valid     = 1'b1;
    op_desc      = {ta, 3'(lm), unm};
    sew_log2     = 2'(sew);
    esz_log2     = 2'(esz);
    vstart       = VL_W'(vs);
    vl           = VL_W'(vln);
    reg_idx      = REG_W'(rg);
    fill_ones_en = cfg;
    expect_for(lm, sew, esz, vs, vln, rg, unm, ta, cfg, er, eo, ec);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || result_we !== er || ones_we !== eo || vstart_clr !== ec) begin
      failures++;
      $display("FAIL %s: got v=%b res=%h ones=%h clr=%b expected v=1 res=%h ones=%h clr=%b",
               req, out_valid, result_we, ones_we, vstart_clr, er, eo, ec);
    end
  endtask

  task automatic idle_check(input string req);
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result_we !== '0 || ones_we !== '0 || vstart_clr !== 1'b0) begin
      failures++;
      $display("FAIL %s: got v=%b res=%h ones=%h clr=%b expected all zero",
               req, out_valid, result_we, ones_we, vstart_clr);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240510);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result_we !== '0 || ones_we !== '0 || vstart_clr !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got v=%b res=%h ones=%h expected zeros", out_valid, result_we, ones_we);
    end
    rst_n = 1'b1;
    v0_mask = {$urandom, $urandom, $urandom, $urandom};

    // R8 / R2: full register body, fill active, nothing left for tail
    run_op("R8 exact fit", 0, 0, 0, 0, 16, 0, 1'b1, 1'b1, 1'b1);
    // R7 / R11: fractional multiplier -1 (code 3'b111), fill past VLMAX
    run_op("R7 fractional fill", -1, 0, 0, 0, 8, 0, 1'b1, 1'b1, 1'b1);
    // R5: policy bit set, global enable clear -> tail untouched
    run_op("R5 cfg off", -1, 0, 0, 0, 8, 0, 1'b1, 1'b1, 1'b0);
    // R5: global enable set, policy bit clear
    run_op("R5 policy off", -2, 1, 1, 0, 2, 0, 1'b1, 1'b0, 1'b1);
    // R9: vstart beyond vl
    run_op("R9 early exit", 0, 0, 0, 10, 5, 0, 1'b1, 1'b1, 1'b1);
    // R4 / R3: masked with prestart
    run_op("R4 prestart masked", 0, 0, 0, 3, 12, 0, 1'b0, 1'b1, 1'b1);
    run_op("R3 masked halfword", 1, 1, 1, 0, 14, 1, 1'b0, 1'b0, 1'b0);
    // R12 / R6: widening byte->halfword, two-register group
    run_op("R12 widen reg0", 0, 0, 1, 0, 5, 0, 1'b1, 1'b1, 1'b1);
    run_op("R10 widen last reg", 0, 0, 1, 0, 5, 1, 1'b1, 1'b1, 1'b1);
    // R6: multiplier 8, tail in a middle register
    run_op("R6 group tail", 3, 0, 0, 2, 70, 4, 1'b1, 1'b1, 1'b1);
    idle_check("R1 idle");

    for (int i = 0; i < 3000; i++) begin
      int sew, esz, lm, vlmax, vln, vs, em, rg;
      sew = int'($urandom % 4);
      esz = sew;
      if (sew < 3 && ($urandom % 3) == 0) esz = sew + 1;
      lm = int'($urandom % 7) - 3;
      if (esz - sew + lm > 3) lm = 3 - (esz - sew);
      vlmax = (lm >= 0) ? ((VLENB << lm) >> sew) : ((VLENB >> (-lm)) >> sew);
      vln = int'($urandom % (vlmax + 1));
      vs = int'($urandom % (vlmax + 2));
      if (($urandom % 4) != 0 && vs > vln) vs = 0;
      em = esz - sew + lm;
      if (em < 0) em = 0;
      rg = int'($urandom % (1 << em));
      if (($urandom % 8) == 0) v0_mask = {$urandom, $urandom, $urandom, $urandom};
      run_op("R6 random", lm, sew, esz, vs, vln, rg,
             1'($urandom), 1'($urandom), 1'($urandom));
      if (($urandom % 16) == 0) idle_check("R1 random idle");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule